// File: doc/BRIEF.md
# Trigger Latency and Jitter Monitor

This block measures how consistently a haptic execution path fires. It stamps three asynchronous strobes against one free-running tick counter: the compare-fire strobe, the execution marker, and the drive-start edge. For every trigger it forms the marker-to-drive latency. It folds accepted latencies into a window of N triggers and reports the minimum, the maximum, the peak-to-peak spread (the jitter) and the sum. The floored mean of the window is reported apart from the spread as the calibratable offset.

The delay from compare-fire to marker is reported on its own as the execution-delay metric. Two classification counters track the triggers that go wrong. A trigger is a miss when a compare produces no marker, or a marker produces no drive edge, within a programmable timeout. A trigger is late when its marker timestamp lies after the target tick supplied with it. Missed triggers never enter the statistics.

Top module: `trig_latency_mon`

## Requirements
- R1: Each strobe passes through a two-flop synchronizer and is acted on only at its rising edge. A marker raised in the cycle before clock edge a, followed by a drive edge raised in the cycle before edge a+L, yields a latency of exactly L ticks.
- R2: The window length is win_n_i clamped to the range 10..30. When the N-th accepted latency of a window arrives, the readout outputs update and win_done_o is high for exactly one cycle. Before that, the readouts keep the previous window's values, which are all zero after reset.
- R3: lat_min_o and lat_max_o hold the smallest and largest latency of the last completed window. lat_spread_o holds their difference.
- R4: lat_sum_o holds the sum of the window's latencies. lat_mean_o holds that sum divided by N, rounded down, as the offset figure.
- R5: In the cycle a window closes, the accumulators clear, so the next window's results depend only on its own samples.
- R6: When a marker follows a pending compare-fire within the timeout, exec_dly_o takes the marker timestamp minus the fire timestamp. A marker with no pending fire leaves it unchanged.
- R7: miss_cnt_o increments when a pending compare-fire sees no marker within timeout_i ticks. It also increments when the fire is superseded by a new fire before its marker arrives.
- R8: miss_cnt_o increments when a marker sees no drive edge within timeout_i ticks. That trigger contributes nothing to the window and does not advance the window count.
- R9: The marker timestamp equals the tick count in the cycle the marker was raised, which removes the two synchronizer cycles. late_cnt_o increments when that timestamp minus target_i, taken as a signed 32-bit modular difference, is greater than zero. Equal is on time, and a target numerically far above the timestamp can still count as past.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| marker_i | input | 1 | Execution marker strobe, asynchronous |
| drive_i | input | 1 | Drive-start / enable strobe, asynchronous |
| fire_i | input | 1 | Compare-fire strobe, asynchronous |
| win_n_i | input | 5 | Requested window length in triggers |
| timeout_i | input | 16 | Pairing timeout in ticks |
| target_i | input | 32 | Target tick of the current marker |
| lat_min_o | output | 32 | Window minimum latency |
| lat_max_o | output | 32 | Window maximum latency |
| lat_spread_o | output | 32 | Window peak-to-peak latency |
| lat_sum_o | output | 32 | Window latency sum |
| lat_mean_o | output | 32 | Window mean latency (offset) |
| exec_dly_o | output | 32 | Last fire-to-marker delay |
| miss_cnt_o | output | 16 | Missed trigger count |
| late_cnt_o | output | 16 | Late marker count |
| win_done_o | output | 1 | One-cycle window completion pulse |

## Verification
A strobe raised before clock edge k is acted on at edge k+2. Every result (readouts, win_done_o, exec_dly_o and both counters) is therefore visible after that edge. Each stimulus task drives inputs on falling edges and then idles at least six cycles before it compares outputs, so no check lands in the two-cycle pipeline. Timeout misses are due timeout_i+3 cycles after the strobe, and the bench waits well beyond that. Late decisions are checked at the exact boundary by setting the target from a cycle counter that the bench keeps itself.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int TS_W = 32;
  typedef logic [TS_W-1:0] ts_t;

  // modular distance from an earlier stamp to a later one
  function automatic ts_t mod_delta(ts_t later, ts_t earlier);
    return later - earlier;
  endfunction

  // strictly after the target, signed modular sense
  function automatic logic is_after(ts_t ts, ts_t tgt);
    ts_t d;
    d = ts - tgt;
    return (d != '0) && !d[TS_W-1];
  endfunction

  function automatic ts_t pick_min(ts_t a, ts_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic ts_t pick_max(ts_t a, ts_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clamp_win(int raw, int lo, int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  function automatic ts_t mean_div(ts_t sum, ts_t n);
    if (n == '0) return '0;
    return sum / n;
  endfunction
endpackage

// File: rtl/tlm_edge_sync.sv
module tlm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R1
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tlm_event_track.sv
module tlm_event_track
  import tlm_pkg::*;
#(
  parameter int TO_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ts_t              now_ts,
  input  logic             fire_rise,
  input  logic             mark_rise,
  input  logic             drv_rise,
  input  ts_t              target,
  input  logic [TO_W-1:0]  timeout,
  output logic             smp_valid,
  output ts_t              smp_lat,
  output ts_t              exec_dly,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] late_cnt
);
  logic fire_pend_q, wait_drv_q;
  ts_t  fire_ts_q, mark_ts_q, to_ext;
  ts_t  fire_elapsed, drv_elapsed;
  logic fire_expire, drv_expire, pair_exec, fire_miss, drv_miss, late_evt;

  assign to_ext       = {{(TS_W-TO_W){1'b0}}, timeout};
  assign fire_elapsed = mod_delta(now_ts, fire_ts_q);
  assign drv_elapsed  = mod_delta(now_ts, mark_ts_q);
  assign fire_expire  = fire_pend_q && (fire_elapsed > to_ext);
  assign drv_expire   = wait_drv_q && (drv_elapsed > to_ext);
  assign pair_exec    = mark_rise && fire_pend_q && !fire_expire;
  assign smp_valid    = drv_rise && wait_drv_q && !drv_expire;
  assign smp_lat      = drv_elapsed;
  assign fire_miss    = fire_pend_q && !pair_exec && (fire_expire || fire_rise);
  assign drv_miss     = wait_drv_q && !smp_valid && (drv_expire || mark_rise);
  assign late_evt     = mark_rise && is_after(now_ts, target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_pend_q <= 1'b0;
      wait_drv_q  <= 1'b0;
      fire_ts_q   <= '0;
      mark_ts_q   <= '0;
      exec_dly    <= '0;
      miss_cnt    <= '0;
      late_cnt    <= '0;
    end else begin
      if (fire_rise) begin
        fire_pend_q <= 1'b1;
        fire_ts_q   <= now_ts;
      end else if (pair_exec || fire_expire) begin
        fire_pend_q <= 1'b0;
      end
      if (mark_rise) begin
        wait_drv_q <= 1'b1;
        mark_ts_q  <= now_ts;
      end else if (smp_valid || drv_expire) begin
        wait_drv_q <= 1'b0;
      end
      if (pair_exec) exec_dly <= mod_delta(now_ts, fire_ts_q);
      miss_cnt <= miss_cnt + CNT_W'(fire_miss) + CNT_W'(drv_miss);
      if (late_evt) late_cnt <= late_cnt + 1'b1;
    end
  end

  // R7
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt != $past(miss_cnt)) |-> ($past(fire_pend_q) || $past(wait_drv_q)));
  // R9
  late_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late_cnt != $past(late_cnt)) |-> $past(mark_rise));
  // R6
  exec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_dly != $past(exec_dly)) |-> $past(mark_rise));
endmodule

// File: rtl/tlm_window_stats.sv
module tlm_window_stats
  import tlm_pkg::*;
#(
  parameter int WIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  ts_t              smp_lat,
  input  logic [WIN_W-1:0] win_n,
  output ts_t              rd_min,
  output ts_t              rd_max,
  output ts_t              rd_spread,
  output ts_t              rd_sum,
  output ts_t              rd_mean,
  output logic             win_done
);
  ts_t              acc_min, acc_max, acc_sum, nxt_min, nxt_max, nxt_sum;
  logic [WIN_W-1:0] acc_cnt, nxt_cnt, rd_n;
  logic             win_close;

  assign nxt_min   = pick_min(acc_min, smp_lat);
  assign nxt_max   = pick_max(acc_max, smp_lat);
  assign nxt_sum   = acc_sum + smp_lat;
  assign nxt_cnt   = acc_cnt + 1'b1;
  assign win_close = smp_valid && (nxt_cnt >= win_n);
  assign rd_mean   = mean_div(rd_sum, TS_W'(rd_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_min <= '1; acc_max <= '0; acc_sum <= '0; acc_cnt <= '0;
      rd_min <= '0; rd_max <= '0; rd_spread <= '0; rd_sum <= '0; rd_n <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= win_close;
      if (win_close) begin
        rd_min    <= nxt_min;
        rd_max    <= nxt_max;
        rd_spread <= mod_delta(nxt_max, nxt_min);
        rd_sum    <= nxt_sum;
        rd_n      <= win_n;
        acc_min <= '1; acc_max <= '0; acc_sum <= '0; acc_cnt <= '0;
      end else if (smp_valid) begin
        acc_min <= nxt_min;
        acc_max <= nxt_max;
        acc_sum <= nxt_sum;
        acc_cnt <= nxt_cnt;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);
  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt != '0) |-> (acc_min <= acc_max));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (acc_cnt == '0 && acc_sum == '0));
  // R3
  readout_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (rd_min <= rd_max));
endmodule

// File: rtl/trig_latency_mon.sv
module trig_latency_mon
  import tlm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_W       = 5,
  parameter int WIN_MIN     = 10,
  parameter int WIN_MAX     = 30,
  parameter int TO_W        = 16,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             marker_i,
  input  logic             drive_i,
  input  logic             fire_i,
  input  logic [WIN_W-1:0] win_n_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic [31:0]      target_i,
  output logic [31:0]      lat_min_o,
  output logic [31:0]      lat_max_o,
  output logic [31:0]      lat_spread_o,
  output logic [31:0]      lat_sum_o,
  output logic [31:0]      lat_mean_o,
  output logic [31:0]      exec_dly_o,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] late_cnt_o,
  output logic             win_done_o
);
  localparam int NSTROBE = 3;
  localparam int IDX_MRK = 0, IDX_DRV = 1, IDX_FIRE = 2;

  ts_t              tick_q, now_ts, smp_lat;
  logic [NSTROBE-1:0] raw, rise;
  logic [WIN_W-1:0] eff_n;
  logic             smp_valid;

  assign raw    = {fire_i, drive_i, marker_i};
  assign now_ts = tick_q - TS_W'(SYNC_STAGES);
  assign eff_n  = WIN_W'(clamp_win(int'(win_n_i), WIN_MIN, WIN_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_q + 1'b1;
  end

  for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
    tlm_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw[g]), .rise_o(rise[g]));
  end

  tlm_event_track #(.TO_W(TO_W), .CNT_W(CNT_W)) i_track (
    .clk(clk), .rst_n(rst_n), .now_ts(now_ts),
    .fire_rise(rise[IDX_FIRE]), .mark_rise(rise[IDX_MRK]), .drv_rise(rise[IDX_DRV]),
    .target(target_i), .timeout(timeout_i),
    .smp_valid(smp_valid), .smp_lat(smp_lat), .exec_dly(exec_dly_o),
    .miss_cnt(miss_cnt_o), .late_cnt(late_cnt_o));

  tlm_window_stats #(.WIN_W(WIN_W)) i_stats (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_lat(smp_lat),
    .win_n(eff_n), .rd_min(lat_min_o), .rd_max(lat_max_o),
    .rd_spread(lat_spread_o), .rd_sum(lat_sum_o), .rd_mean(lat_mean_o),
    .win_done(win_done_o));

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_n >= WIN_W'(WIN_MIN)) && (eff_n <= WIN_W'(WIN_MAX)));
endmodule

// File: tb/test_trig_latency_mon.sv
module test_trig_latency_mon;
  logic clk = 0, rst_n = 0;
  logic marker = 0, drive = 0, fire = 0;
  logic [4:0] win_n = 10;
  logic [15:0] tmo = 20;
  logic [31:0] target = 32'h4000_0000;
  logic [31:0] mn, mx, spr, sm, mean, exd;
  logic [15:0] miss, late;
  logic done;
  int n_chk = 0, n_fail = 0, done_cnt = 0;
  logic [31:0] cyc = 0;

  always #2 clk = ~clk;

  trig_latency_mon i_trig_latency_mon (
    .clk(clk), .rst_n(rst_n), .marker_i(marker), .drive_i(drive), .fire_i(fire),
    .win_n_i(win_n), .timeout_i(tmo), .target_i(target),
    .lat_min_o(mn), .lat_max_o(mx), .lat_spread_o(spr), .lat_sum_o(sm),
    .lat_mean_o(mean), .exec_dly_o(exd), .miss_cnt_o(miss), .late_cnt_o(late),
    .win_done_o(done));

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;
  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic trig(int lat);
    @(negedge clk) marker = 1;
    repeat (lat) @(negedge clk);
    drive = 1;
    repeat (2) @(negedge clk);
    marker = 0; drive = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset min", mn, 0); chk("R2 reset max", mx, 0);
    chk("R4 reset mean", mean, 0); chk("R7 reset miss", miss, 0);
    chk("R9 reset late", late, 0); chk("R2 reset done", done, 0);
  endtask

  task automatic t_window1();
    int lats[10] = '{5, 9, 3, 7, 12, 4, 6, 8, 10, 11};
    win_n = 10;
    for (int i = 0; i < 9; i++) trig(lats[i]);
    chk("R2 no done before Nth", done_cnt, 0);
    chk("R2 readout held", mx, 0);
    trig(lats[9]);
    chk("R2 done once", done_cnt, 1);
    chk("R1 R3 min", mn, 3); chk("R3 max", mx, 12); chk("R3 spread", spr, 9);
    chk("R4 sum", sm, 75); chk("R4 mean floor", mean, 7);
  endtask

  task automatic t_window2();
    win_n = 12;
    for (int i = 0; i < 11; i++) trig(2 + i);
    chk("R2 window12 not yet", done_cnt, 1);
    chk("R5 prior readout kept", mx, 12);
    trig(13);
    chk("R2 window12 done", done_cnt, 2);
    chk("R5 min", mn, 2); chk("R5 max", mx, 13); chk("R3 spread", spr, 11);
    chk("R4 sum", sm, 90); chk("R4 mean", mean, 7);
  endtask

  task automatic t_clamp_drop();
    win_n = 3;
    for (int i = 0; i < 5; i++) trig(6);
    @(negedge clk) marker = 1;
    repeat (3) @(negedge clk);
    marker = 0;
    repeat (35) @(negedge clk);
    chk("R8 drive timeout miss", miss, 1);
    for (int i = 0; i < 4; i++) trig(6);
    chk("R8 R2 miss excluded, clamp to 10", done_cnt, 2);
    trig(6);
    chk("R2 clamped window done", done_cnt, 3);
    chk("R3 flat spread", spr, 0); chk("R4 sum 60", sm, 60); chk("R4 mean 6", mean, 6);
  endtask

  task automatic t_exec();
    win_n = 10;
    @(negedge clk) fire = 1;
    repeat (4) @(negedge clk);
    marker = 1; fire = 0;
    repeat (3) @(negedge clk);
    drive = 1;
    repeat (2) @(negedge clk);
    marker = 0; drive = 0;
    repeat (6) @(negedge clk);
    chk("R6 exec delay", exd, 4);
    chk("R7 no miss on pair", miss, 1);
    trig(3);
    chk("R6 unchanged without fire", exd, 4);
  endtask

  task automatic t_fire_miss();
    @(negedge clk) fire = 1;
    repeat (2) @(negedge clk) fire = 0;
    repeat (40) @(negedge clk);
    chk("R7 fire timeout miss", miss, 2);
    chk("R7 exec unchanged", exd, 4);
    @(negedge clk) fire = 1;
    repeat (2) @(negedge clk); fire = 0;
    repeat (3) @(negedge clk); fire = 1;
    repeat (3) @(negedge clk);
    marker = 1; fire = 0;
    repeat (2) @(negedge clk); drive = 1;
    repeat (2) @(negedge clk);
    marker = 0; drive = 0;
    repeat (6) @(negedge clk);
    chk("R7 superseded fire miss", miss, 3);
    chk("R6 exec from newer fire", exd, 3);
  endtask

  task automatic late_trig(logic [31:0] tgt_off, logic absolute);
    @(negedge clk);
    target = absolute ? tgt_off : cyc + tgt_off;
    marker = 1;
    repeat (2) @(negedge clk); drive = 1;
    repeat (2) @(negedge clk);
    marker = 0; drive = 0;
    repeat (6) @(negedge clk);
    target = 32'h4000_0000;
  endtask

  task automatic t_late();
    chk("R9 no late so far", late, 0);
    late_trig(0, 0);
    chk("R9 equal is on time", late, 0);
    late_trig(32'hFFFF_FFFF, 0);
    chk("R9 one tick after target", late, 1);
    late_trig(32'hFFFF_FFF0, 1);
    chk("R9 modular past target", late, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_window1();
    t_window2();
    t_clamp_drop();
    t_exec();
    t_fire_miss();
    t_late();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule